// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer for a system bus. It has three 32-bit registers: settings, command and limit. A free-running counter advances on an external tick strobe. When the counter passes the programmed limit while the watchdog is armed, the block issues a one-cycle reset request. Software keeps the system alive by writing a refresh key to the command register, which sets the counter back to zero.

The settings and limit registers are protected. Software must first write an unlock key to the command register. That opens a short window during which exactly one protected write is accepted. Each key can be written as a single 32-bit word, or as two 16-bit halves written one after the other; a settings bit chooses the form. Two read-only flags report the state of this protection: one shows that the window is open, and the other shows that a protected write has taken effect. Software can also clear a permission bit, which refuses all later unlocks until reset. Two low-power inputs can pause counting, unless the matching settings bit allows counting in that power state.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, these registers read as follows. Settings (offset 0x0) reads 0x0000_0020: only bit 5 (update permission) is set. Limit (offset 0x8) reads the value of the parameter TOV_RST, which defaults to 1000. Counter (offset 0x4) reads 0. Unmapped offsets read 0.
- R2: Key form depends on settings bit 13. With bit 13 at 0, the unlock key is 0x0000C520 followed directly by 0x0000D928, and the refresh key is 0x0000A602 followed directly by 0x0000B480. Both words are written to offset 0x4. Any other write to that offset in between discards the first half.
- R3: With settings bit 13 at 1, only a single write of 0xD928C520 unlocks, and only a single write of 0xB480A602 refreshes. The 16-bit halves have no effect in this mode.
- R4: The unlocked flag (settings bit 11) reads 1 in the first cycle after the write that completes the unlock key.
- R5: A write to the settings or limit register while the unlocked flag is 0 leaves that register unchanged.
- R6: A protected write is accepted while unlocked. It updates the register, sets the reconfig-done flag (settings bit 10), and clears the unlocked flag. A later unlock clears the reconfig-done flag.
- R7: The unlock window closes by itself WIN_CYC bus cycles after it opened (default 256).
- R8: After an accepted settings write that leaves bit 5 at 0, every later unlock is refused until reset.
- R9: While armed (settings bit 7), each tick adds one to the counter. A refresh sets the counter to 0. While disarmed, the counter is held at 0.
- R10: If a tick arrives while armed and the counter is at or above the limit, the counter returns to 0 and `wdog_rst` is high for exactly one cycle. The first request therefore comes on the (limit+1)th tick after a refresh.
- R11: With `stop_mode` high and settings bit 0 at 0, ticks do not change the counter. The same holds for `wait_mode` with settings bit 1. With the matching bit at 1, counting continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Byte offset of the read |
| rd_data | output | 32 | Read data for rd_addr (combinational) |
| tick | input | 1 | Count strobe, one bus cycle wide |
| stop_mode | input | 1 | System is in the stop low-power state |
| wait_mode | input | 1 | System is in the wait low-power state |
| wdog_rst | output | 1 | One-cycle reset request |

## Verification
The bench breaks a 16-bit key pair with a foreign value and expects no unlock. A detector that keeps the half-key state across the foreign write would wrongly unlock.

It writes 16-bit halves while in 32-bit mode and expects the counter to be unaffected. A design that ignores the mode bit would refresh.

It checks that the reset request comes on the tick after the counter reaches the limit, not on the tick that reaches it. An off-by-one compare would fire one tick early.

It waits past the window, and it clears the permission bit. A design that leaves the window open, or keeps honouring unlocks, lets the limit register change when it should not.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
   localparam logic [3:0] OFF_CTRL = 4'h0;
   localparam logic [3:0] OFF_CMD  = 4'h4;
   localparam logic [3:0] OFF_TOV  = 4'h8;

   localparam logic [15:0] UNLK_LO = 16'hC520;
   localparam logic [15:0] UNLK_HI = 16'hD928;
   localparam logic [15:0] RFSH_LO = 16'hA602;
   localparam logic [15:0] RFSH_HI = 16'hB480;

   localparam int B_WIDE  = 13;
   localparam int B_ULK   = 11;
   localparam int B_RCFG  = 10;
   localparam int B_CLK   = 8;
   localparam int B_ARM   = 7;
   localparam int B_UPD   = 5;
   localparam int B_WAITR = 1;
   localparam int B_STOPR = 0;
endpackage

// File: rtl/wdt_key_match.sv
`timescale 1ns/1ps
module wdt_key_match
   import wdt_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_wr,
   input  logic [31:0] wdata,
   input  logic        wide,
   output logic        unlock_hit,
   output logic        refresh_hit
);
   logic half_unlk_q, half_rfsh_q;

   always_comb begin
      if (wide) begin
         unlock_hit  = cmd_wr && (wdata == {UNLK_HI, UNLK_LO});
         refresh_hit = cmd_wr && (wdata == {RFSH_HI, RFSH_LO});
      end else begin
         unlock_hit  = cmd_wr && half_unlk_q && (wdata == {16'h0, UNLK_HI});
         refresh_hit = cmd_wr && half_rfsh_q && (wdata == {16'h0, RFSH_HI});
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_unlk_q <= 1'b0;
         half_rfsh_q <= 1'b0;
      end else if (cmd_wr) begin
         half_unlk_q <= !wide && (wdata == {16'h0, UNLK_LO});
         half_rfsh_q <= !wide && (wdata == {16'h0, RFSH_LO});
      end
   end
endmodule

// File: rtl/wdt_unlock_gate.sv
`timescale 1ns/1ps
module wdt_unlock_gate #(
   parameter int WIN_CYC = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic unlock_hit,
   input  logic cfg_done,
   input  logic upd_allow,
   output logic unlocked
);
   localparam int TW = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
   localparam logic [TW-1:0] TLOAD = TW'(WIN_CYC - 1);

   logic [TW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unlocked <= 1'b0;
         left_q   <= '0;
      end else if (cfg_done) begin
         unlocked <= 1'b0;
      end else if (unlock_hit && upd_allow) begin
         unlocked <= 1'b1;
         left_q   <= TLOAD;
      end else if (unlocked) begin
         if (left_q == '0) unlocked <= 1'b0;
         else              left_q   <= left_q - 1'b1;
      end
   end
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter #(
   parameter int CNT_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             armed,
   input  logic             tick,
   input  logic             hold,
   input  logic             refresh,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] cnt,
   output logic             fire
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         fire <= 1'b0;
      end else begin
         fire <= 1'b0;
         if (!armed || refresh) begin
            cnt <= '0;
         end else if (tick && !hold) begin
            if (cnt >= limit) begin
               cnt  <= '0;
               fire <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/keyed_wdt.sv
`timescale 1ns/1ps
module keyed_wdt
   import wdt_pkg::*;
#(
   parameter int CNT_W   = 17,
   parameter int WIN_CYC = 256,
   parameter int TOV_RST = 1000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [3:0]  wr_addr,
   input  logic [31:0] wr_data,
   input  logic [3:0]  rd_addr,
   output logic [31:0] rd_data,
   input  logic        tick,
   input  logic        stop_mode,
   input  logic        wait_mode,
   output logic        wdog_rst
);
   localparam logic [CNT_W-1:0] TOV_INIT = CNT_W'(TOV_RST);

   generate
      if (CNT_W < 8 || CNT_W > 32) begin : g_bad_cnt_w
         $error("CNT_W must lie in 8..32");
      end
      if (WIN_CYC < 2) begin : g_bad_win
         $error("WIN_CYC must be at least 2");
      end
      if (TOV_RST < 1 || TOV_RST >= (64'd1 << CNT_W)) begin : g_bad_tov
         $error("TOV_RST does not fit CNT_W");
      end
   endgenerate

   logic             r_wide, r_arm, r_upd, r_waitr, r_stopr, r_rcfg;
   logic [1:0]       r_clk;
   logic [CNT_W-1:0] r_tov;
   logic [CNT_W-1:0] cnt;
   logic             unlocked, unlock_hit, refresh_hit;
   logic             cmd_wr, ctrl_wr, tov_wr, cfg_done, hold;

   assign cmd_wr   = wr_en && (wr_addr == OFF_CMD);
   assign ctrl_wr  = wr_en && (wr_addr == OFF_CTRL) && unlocked;
   assign tov_wr   = wr_en && (wr_addr == OFF_TOV) && unlocked;
   assign cfg_done = ctrl_wr || tov_wr;
   assign hold     = (stop_mode && !r_stopr) || (wait_mode && !r_waitr);

   wdt_key_match u_keys (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .wdata(wr_data),
      .wide(r_wide), .unlock_hit(unlock_hit), .refresh_hit(refresh_hit)
   );

   wdt_unlock_gate #(.WIN_CYC(WIN_CYC)) u_gate (
      .clk(clk), .rst_n(rst_n), .unlock_hit(unlock_hit),
      .cfg_done(cfg_done), .upd_allow(r_upd), .unlocked(unlocked)
   );

   wdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .armed(r_arm), .tick(tick), .hold(hold),
      .refresh(refresh_hit), .limit(r_tov), .cnt(cnt), .fire(wdog_rst)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_wide  <= 1'b0;
         r_arm   <= 1'b0;
         r_upd   <= 1'b1;
         r_waitr <= 1'b0;
         r_stopr <= 1'b0;
         r_clk   <= 2'b00;
         r_rcfg  <= 1'b0;
         r_tov   <= TOV_INIT;
      end else begin
         if (ctrl_wr) begin
            r_wide  <= wr_data[B_WIDE];
            r_arm   <= wr_data[B_ARM];
            r_upd   <= wr_data[B_UPD];
            r_waitr <= wr_data[B_WAITR];
            r_stopr <= wr_data[B_STOPR];
            r_clk   <= wr_data[B_CLK+1:B_CLK];
         end
         if (tov_wr) r_tov <= wr_data[CNT_W-1:0];
         if (cfg_done)                 r_rcfg <= 1'b1;
         else if (unlock_hit && r_upd) r_rcfg <= 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         OFF_CTRL: begin
            rd_data[B_WIDE]         = r_wide;
            rd_data[B_ULK]          = unlocked;
            rd_data[B_RCFG]         = r_rcfg;
            rd_data[B_CLK+1:B_CLK]  = r_clk;
            rd_data[B_ARM]          = r_arm;
            rd_data[B_UPD]          = r_upd;
            rd_data[B_WAITR]        = r_waitr;
            rd_data[B_STOPR]        = r_stopr;
         end
         OFF_CMD: rd_data[CNT_W-1:0] = cnt;
         OFF_TOV: rd_data[CNT_W-1:0] = r_tov;
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/keyed_wdt_sva.sv
`timescale 1ns/1ps
module keyed_wdt_sva #(
   parameter int CNT_W = 17
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [3:0]       wr_addr,
   input logic             unlocked,
   input logic             upd_allow,
   input logic             armed,
   input logic             tick,
   input logic [CNT_W-1:0] limit,
   input logic             wdog_rst
);
   assert_rst_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst |=> !wdog_rst);

   assert_rst_needs_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst |-> $past(armed && tick));

   assert_locked_tov_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 4'h8 && !unlocked) |=> $stable(limit));

   assert_unlock_from_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(wr_en && wr_addr == 4'h4));

   assert_no_unlock_when_barred_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_allow |-> !unlocked);
endmodule

bind keyed_wdt keyed_wdt_sva #(.CNT_W(CNT_W)) u_sva (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .unlocked(unlocked), .upd_allow(r_upd), .armed(r_arm), .tick(tick),
   .limit(r_tov), .wdog_rst(wdog_rst)
);

// File: tb/tb_keyed_wdt.sv
`timescale 1ns/1ps
module tb_keyed_wdt;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        tick = 1'b0, stop_mode = 1'b0, wait_mode = 1'b0;
   logic        wdog_rst;

   int total = 0, bad = 0, rst_seen = 0;
   bit done = 1'b0;

   typedef struct { logic [3:0] a; logic [31:0] exp; string tag; } item_t;
   item_t q[$];

   always #10 clk = ~clk;

   keyed_wdt dut (.*);

   task automatic chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      rd_addr = (a == 4'hF) ? 4'h0 : a;
      q.push_back('{a, exp, tag});
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   // monitor: samples away from the edge, pops expected items
   initial forever begin
      @(negedge clk); #5;
      if (wdog_rst) rst_seen++;
      while (q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = q.pop_front();
         act = (it.a == 4'hF) ? 32'(rst_seen) : rd_data;
         total++;
         if (act !== it.exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
         end
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(4'h0, 32'h20, "R1 ctrl reset");
      chk(4'h8, 32'd1000, "R1 limit reset");
      chk(4'h4, 32'd0, "R1 count reset");
      chk(4'hC, 32'd0, "R1 unmapped");
      wr(4'h8, 32'd5);
      chk(4'h8, 32'd1000, "R5 locked limit write ignored");
      // 16-bit unlock
      wr(4'h4, 32'h0000C520); wr(4'h4, 32'h0000D928);
      chk(4'h0, 32'h820, "R2 R4 narrow unlock");
      wr(4'h8, 32'd5);
      chk(4'h8, 32'd5, "R6 limit written");
      chk(4'h0, 32'h420, "R6 rcfg set, window closed");
      // interrupted pair
      wr(4'h4, 32'h0000C520); wr(4'h4, 32'h00001234); wr(4'h4, 32'h0000D928);
      chk(4'h0, 32'h420, "R2 interrupted pair refused");
      // arm in wide mode
      wr(4'h4, 32'h0000C520); wr(4'h4, 32'h0000D928);
      chk(4'h0, 32'h820, "R6 unlock clears rcfg");
      wr(4'h0, 32'h000020A0);
      chk(4'h0, 32'h24A0, "R6 settings written");
      ticks(3);
      chk(4'h4, 32'd3, "R9 counts ticks");
      wr(4'h4, 32'h0000A602); wr(4'h4, 32'h0000B480);
      chk(4'h4, 32'd3, "R3 halves ignored in wide mode");
      wr(4'h4, 32'hB480A602);
      chk(4'h4, 32'd0, "R3 R9 wide refresh");
      ticks(5);
      chk(4'h4, 32'd5, "R10 at limit");
      chk(4'hF, 32'd0, "R10 no request yet");
      ticks(1);
      chk(4'hF, 32'd1, "R10 request on next tick");
      chk(4'h4, 32'd0, "R10 counter back to 0");
      // power-state gating
      stop_mode = 1'b1; ticks(2);
      chk(4'h4, 32'd0, "R11 stop holds");
      stop_mode = 1'b0; wait_mode = 1'b1; ticks(2);
      chk(4'h4, 32'd0, "R11 wait holds");
      wait_mode = 1'b0;
      wr(4'h4, 32'hD928C520);
      chk(4'h0, 32'h28A0, "R3 R4 wide unlock");
      wr(4'h0, 32'h000020A1);
      stop_mode = 1'b1; ticks(2); stop_mode = 1'b0;
      chk(4'h4, 32'd2, "R11 stop counts when allowed");
      // window expiry
      wr(4'h4, 32'hD928C520);
      repeat (300) @(negedge clk);
      chk(4'h0, 32'h20A1, "R7 window closed");
      wr(4'h8, 32'd9);
      chk(4'h8, 32'd5, "R7 limit kept after expiry");
      // update lock
      wr(4'h4, 32'hD928C520);
      wr(4'h0, 32'h00002081);
      chk(4'h0, 32'h2481, "R8 permission cleared");
      wr(4'h4, 32'hD928C520);
      chk(4'h0, 32'h2481, "R8 unlock refused");
      wr(4'h8, 32'd9);
      chk(4'h8, 32'd5, "R8 limit kept");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule